// File: doc/BRIEF.md
# Wait-State External Memory Read Sequencer

This block runs read cycles from a processor core to external memory that is split into four independently selected segments: an instruction/coefficient ROM, an upper data RAM, an I/O space and a lower data RAM. Each segment has its own active-low enable. Each segment also has its own wait count, which is held in a 4-bit field of a single wait-state register. A read with wait count W keeps the chosen enable low for W+1 clock periods. At the final edge the block captures the external data bus and returns the word to the core with a one-period done pulse.

All state in the block changes on the falling edge of `clk`, which stands in for the clock output that the external memory sees. The core raises `req` with a segment number and an address, and holds them while `busy` is high. The address is driven on the same edge that the enable falls. It stays on the bus after the cycle ends, during idle periods and while the enable is high, until the next accepted request replaces it. The read/write-not strobe stays high, because this block only issues reads.

Top module: `xmem_wait_ctl`

## Requirements
- R1: After reset, all four enables are high, the address bus is 0, the wait-state register reads 0, and both `done` and `busy` are low.
- R2: A read on segment s with wait count W holds `ce_n[s]` low for exactly W+1 clock periods, counted between falling edges.
- R3: On the falling edge that accepts a request, `ab` takes the request address and `ce_n[seg]` goes low together with it.
- R4: After a cycle ends, `ab` keeps the last address unchanged until the next request is accepted.
- R5: The wait count for a segment is a nibble of the register: segment 0 (ROM) uses bits 15:12, segment 1 (upper RAM) uses 11:8, segment 2 (I/O) uses 7:4 and segment 3 (lower RAM) uses 3:0. A `cfg_we` write takes effect on the next falling edge and can be read back on `cfg_rdata`.
- R6: `rdata` equals the value on `db_in` at the last falling edge of the cycle, which is the edge where the enable rises. `done` is high for exactly the one period that follows that edge.
- R7: `busy` is high for the whole time an enable is low. A request that is held while `busy` is high is accepted on the second falling edge after the cycle ends, so one idle period always separates two cycles.
- R8: No more than one segment enable is low at any time.
- R9: `rwn` is high at all times.
- R10: Writing the register while a cycle is running does not change the length of that cycle.
- R11: While no request is present, every enable stays high and `ab` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request from the core, held until accepted |
| seg | input | 2 | Segment number of the request (0 ROM, 1 upper RAM, 2 I/O, 3 lower RAM) |
| addr | input | AW | Address of the request |
| busy | output | 1 | A read cycle is running; any new request waits |
| done | output | 1 | One-period pulse when `rdata` is valid |
| rdata | output | DW | Word captured from the data bus |
| cfg_we | input | 1 | Write strobe for the wait-state register |
| cfg_wdata | input | 16 | Value to write to the wait-state register |
| cfg_rdata | output | 16 | Current wait-state register value |
| ce_n | output | 4 | Active-low enable for each segment |
| ab | output | AW | External address bus |
| rwn | output | 1 | Read/write-not strobe, high for reads |
| db_in | input | DW | External data bus input |

## Verification
Two situations are hard to reach from the ports. The first is a request that is already waiting when a cycle ends, which has to be kept out for exactly one idle period. The bench reaches it by keeping `req` high and switching the segment and address in the first period of a zero-wait cycle. The second is a register write that lands in the middle of a long cycle. The bench starts a three-wait read and writes a zero count in its first period, then counts the low periods that follow. The data bus carries a wrong value until after the first edge of each cycle, so an early capture shows up in `rdata`.

// File: rtl/xmw_pkg.sv
package xmw_pkg;
  localparam int SEGS  = 4;
  localparam int WW    = 4;
  localparam int SEG_W = $clog2(SEGS);
  localparam int CFG_W = SEGS * WW;

  // segment 0 lives in the top nibble, segment SEGS-1 in the bottom one
  function automatic logic [WW-1:0] field_of(input logic [CFG_W-1:0] r,
                                             input logic [SEG_W-1:0] s);
    logic [CFG_W-1:0] sh;
    sh = r >> (WW * (SEGS - 1 - int'(s)));
    return sh[WW-1:0];
  endfunction

  function automatic logic [SEGS-1:0] sel_low(input logic [SEG_W-1:0] s);
    return ~(SEGS'(1) << s);
  endfunction
endpackage

// File: rtl/xmw_cfg_reg.sv
module xmw_cfg_reg
  import xmw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic [SEG_W-1:0] sel,
  output logic [CFG_W-1:0] q,
  output logic [WW-1:0]    wait_sel
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  assign wait_sel = field_of(q, sel);

  a_r5_write_lands: assert property (@(negedge clk) disable iff (!rst_n)
    we |=> q == $past(wdata));
  a_r5_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/xmw_seq.sv
module xmw_seq
  import xmw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [WW-1:0] wait_ld,
  output logic          active,
  output logic          start,
  output logic          finish
);
  logic [WW-1:0] cnt;

  assign start  = req && !active;
  assign finish = active && (cnt == '0);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= wait_ld;
    end else if (finish) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  a_r2_no_early_end: assert property (@(negedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> active);
  a_r7_gap_after_end: assert property (@(negedge clk) disable iff (!rst_n)
    finish |=> !active);
  a_r10_count_down: assert property (@(negedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/xmw_bus_drv.sv
module xmw_bus_drv
  import xmw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             finish,
  input  logic [SEG_W-1:0] seg,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    db_in,
  output logic [SEGS-1:0]  ce_n,
  output logic [AW-1:0]    ab,
  output logic [DW-1:0]    rdata,
  output logic             done
);
  for (genvar g = 0; g < SEGS; g++) begin : g_ce
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)                             ce_n[g] <= 1'b1;
      else if (start && seg == SEG_W'(g))     ce_n[g] <= 1'b0;
      else if (finish)                        ce_n[g] <= 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab    <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (start)  ab    <= addr;
      if (finish) rdata <= db_in;
    end
  end

  a_r8_one_enable: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  a_r4_addr_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !start |=> $stable(ab));
  a_r3_addr_with_enable: assert property (@(negedge clk) disable iff (!rst_n)
    start |=> (ab == $past(addr)) && (ce_n == sel_low($past(seg))));
  a_r6_done_single: assert property (@(negedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_capture: assert property (@(negedge clk) disable iff (!rst_n)
    finish |=> done && rdata == $past(db_in) && ce_n == '1);
endmodule

// File: rtl/xmem_wait_ctl.sv
module xmem_wait_ctl
  import xmw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEG_W-1:0] seg,
  input  logic [AW-1:0]    addr,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rdata,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [SEGS-1:0]  ce_n,
  output logic [AW-1:0]    ab,
  output logic             rwn,
  input  logic [DW-1:0]    db_in
);
  logic [WW-1:0] wait_sel;
  logic          active, start, finish;

  xmw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .sel(seg), .q(cfg_rdata), .wait_sel(wait_sel)
  );

  xmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .wait_ld(wait_sel),
    .active(active), .start(start), .finish(finish)
  );

  xmw_bus_drv #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
    .seg(seg), .addr(addr), .db_in(db_in),
    .ce_n(ce_n), .ab(ab), .rdata(rdata), .done(done)
  );

  assign busy = active;
  assign rwn  = 1'b1;

  a_r7_busy_covers_enable: assert property (@(negedge clk) disable iff (!rst_n)
    (ce_n != '1) |-> busy);
  a_r11_idle_quiet: assert property (@(negedge clk) disable iff (!rst_n)
    (!req && !busy) |=> ce_n == '1);
endmodule

// File: tb/sim_xmem_wait_ctl.sv
module sim_xmem_wait_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  seg = '0;
  logic [15:0] addr = '0;
  logic        busy, done, rwn;
  logic [15:0] rdata, cfg_rdata, ab;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  ce_n;
  logic [15:0] db_in = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] cfg_model = '0;
  logic [15:0] last_ab = '0;

  always #10 clk = ~clk;

  xmem_wait_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .seg(seg), .addr(addr),
    .busy(busy), .done(done), .rdata(rdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ce_n(ce_n),
    .ab(ab), .rwn(rwn), .db_in(db_in)
  );

  function automatic int wait_of(logic [15:0] c, logic [1:0] s);
    case (s)
      2'd0: return int'(c[15:12]);
      2'd1: return int'(c[11:8]);
      2'd2: return int'(c[7:4]);
      default: return int'(c[3:0]);
    endcase
  endfunction

  function automatic logic [3:0] low_mask(logic [1:0] s);
    logic [3:0] m = 4'b1111;
    m[s] = 1'b0;
    return m;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // All tasks begin and end right at a rising edge; the design moves on falling edges.
  task automatic write_cfg(logic [15:0] v);
    #1 cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); #1 cfg_we = 1'b0;
    cfg_model = v;
    @(posedge clk);
    chk(cfg_rdata == v, "R5 readback", cfg_rdata, v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      #1 req = 1'b0;
      @(posedge clk);
      chk(ce_n == 4'hF, "R11 idle enables", ce_n, 4'hF);
      chk(ab == last_ab, "R11 idle address", ab, last_ab);
    end
  endtask

  task automatic run_read(logic [1:0] s, logic [15:0] a, logic [15:0] d, int w);
    #1 req = 1'b1; seg = s; addr = a; db_in = ~d;
    @(posedge clk);
    chk(ce_n == low_mask(s), "R3 enable at start", ce_n, low_mask(s));
    chk(ab == a, "R3 address at start", ab, a);
    chk(busy == 1'b1, "R7 busy", busy, 1);
    chk(rwn == 1'b1, "R9 strobe high", rwn, 1);
    #1 req = 1'b0; db_in = d;
    for (int i = 0; i < w; i++) begin
      @(posedge clk);
      chk(ce_n == low_mask(s), "R2 enable held", ce_n, low_mask(s));
    end
    @(posedge clk);
    chk(ce_n == 4'hF, "R2 enable released after W+1", ce_n, 4'hF);
    chk(done == 1'b1, "R6 done pulse", done, 1);
    chk(rdata == d, "R6 data captured at final edge", rdata, d);
    chk(ab == a, "R4 address held", ab, a);
    #1 db_in = ~d;
    @(posedge clk);
    chk(done == 1'b0, "R6 done single period", done, 0);
    chk(ab == a, "R4 address held", ab, a);
    last_ab = a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    repeat (2) @(posedge clk);
    chk(ce_n == 4'hF, "R1 enables", ce_n, 4'hF);
    chk(ab == 16'h0, "R1 address", ab, 0);
    chk(cfg_rdata == 16'h0, "R1 register", cfg_rdata, 0);
    chk(done == 1'b0 && busy == 1'b0, "R1 done/busy", {done, busy}, 0);
    #1 rst_n = 1'b1;
    @(posedge clk);

    // R5: ROM wait 1 in top nibble, lower RAM wait 2 in bottom nibble
    write_cfg(16'h1002);
    run_read(2'd0, 16'hA001, 16'h1234, 1);
    idle(1);
    run_read(2'd3, 16'hB002, 16'h5678, 2);
    // R5: wait 0 for ROM/lower RAM, upper RAM 5, I/O 3
    write_cfg(16'h0530);
    run_read(2'd1, 16'h0C0C, 16'hBEEF, 5);
    run_read(2'd2, 16'h0D0D, 16'hCAFE, 3);
    run_read(2'd0, 16'h0E0E, 16'hF00D, 0);

    // R7: request waiting across the end of a zero-wait cycle
    write_cfg(16'h0100);
    #1 req = 1'b1; seg = 2'd0; addr = 16'h1111; db_in = 16'h0A0A;
    @(posedge clk);
    chk(ce_n == 4'b1110, "R7 first enable", ce_n, 4'b1110);
    #1 seg = 2'd1; addr = 16'h2222;
    @(posedge clk);
    chk(ce_n == 4'hF, "R7 idle period between cycles", ce_n, 4'hF);
    chk(busy == 1'b0, "R7 busy low in gap", busy, 0);
    chk(ab == 16'h1111, "R7 address kept in gap", ab, 16'h1111);
    chk(rdata == 16'h0A0A, "R6 rdata first", rdata, 16'h0A0A);
    @(posedge clk);
    chk(ce_n == 4'b1101, "R7 second start", ce_n, 4'b1101);
    chk(ab == 16'h2222, "R7 second address", ab, 16'h2222);
    #1 req = 1'b0;
    @(posedge clk);
    chk(ce_n == 4'b1101, "R7 second held", ce_n, 4'b1101);
    @(posedge clk);
    chk(ce_n == 4'hF && done, "R7 second end", {ce_n, done}, 5'h1F);
    last_ab = 16'h2222;
    idle(2);

    // R10: register rewritten mid-cycle
    write_cfg(16'h0030);
    #1 req = 1'b1; seg = 2'd2; addr = 16'h3333;
    @(posedge clk);
    chk(ce_n == 4'b1011, "R10 start", ce_n, 4'b1011);
    #1 req = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h0000;
    @(negedge clk); #1 cfg_we = 1'b0; cfg_model = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      chk(ce_n == 4'b1011, "R10 length unchanged", ce_n, 4'b1011);
    end
    @(posedge clk);
    chk(ce_n == 4'hF, "R10 end on old count", ce_n, 4'hF);
    last_ab = 16'h3333;
    idle(1);

    // random mix, expected timing from the bench's own field decode
    for (int n = 0; n < 40; n++) begin
      logic [1:0]  s;
      logic [15:0] a, d;
      if (n % 5 == 0) write_cfg(16'($urandom));
      s = 2'($urandom);
      a = 16'($urandom);
      d = 16'($urandom);
      idle(int'($urandom % 3));
      run_read(s, a, d, wait_of(cfg_model, s));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule